// File: doc/BRIEF.md
# Timer trigger output selector

This block picks what a timer presents on its single trigger output line. A 4-bit mode input chooses among the timer's internal signals: the software update strobe, the counter run level, the update event, the channel 1 capture/compare flag-set strobe, and six channel compare reference waveforms. Some modes copy one level straight to the output. The others turn edges of one or two reference waveforms into pulses that last one clock.

Several pulse modes merge edges of two different references with OR. Some of these mix polarities, for example a rising edge on one channel or a falling edge on another. Edges are found by comparing each input with its own value one clock earlier. That history is updated on every clock, whatever mode is selected. The output is registered, so every mode has one clock of latency.

Top module: `trig_out_sel`

## Requirements
- R1: A synchronous active-low reset drives the output to 0 and clears all edge history to 0. A reference that is already high when reset is released therefore shows as a rising edge on the first clock after release.
- R2: Modes 0, 1 and 2 copy the software update strobe, the counter enable and the update event, in that order, to the output one clock later.
- R3: Mode 3 gives a one-clock pulse when the channel 1 flag-set strobe rises. A strobe held high gives only one pulse.
- R4: Modes 4 to 9 copy compare references 1 to 6 to the output one clock later. Reference n is bit n-1 of the reference input. Mode 4 selects reference 1.
- R5: Mode 10 pulses on every rising or falling edge of reference 4 (bit 3). Mode 11 does the same for reference 6 (bit 5). No edge means no pulse.
- R6: Mode 12 pulses on a rising edge of reference 4 or reference 6. Mode 14 pulses on a rising edge of reference 5 (bit 4) or reference 6. Falling edges are ignored in both modes.
- R7: Mode 13 pulses on a rising edge of reference 4 or a falling edge of reference 6. Mode 15 does the same with reference 5 in place of reference 4. An edge of the other polarity on either input gives no pulse.
- R8: When both qualifying edges of a combined mode fall on the same clock, the output carries one pulse of one clock.
- R9: Edge history follows the references in every mode. After switching into a pulse mode, an edge that happened while another mode was selected gives no pulse.
- R10: A new mode value controls the output from the clock edge at which it is first sampled.
- R11: Every pulse mode produces pulses exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 4 | Output source / pulse mode |
| sw_update | input | 1 | Software update-generation strobe |
| cnt_en | input | 1 | Counter enable level |
| upd_evt | input | 1 | Update event |
| cc1_flag_set | input | 1 | Channel 1 capture/compare flag-set strobe |
| oc_ref | input | 6 | Compare references; bit n-1 is channel n |
| trig_out | output | 1 | Registered trigger output |

## Verification
The vector walk first sets each level source high and then low on its own, so a wrong selector index shows up as a mismatch. The pulse modes are driven with single edges of each polarity on each channel. Those cases separate a both-edge detector from a rising-only one, and a correct falling-edge term from a swapped one. Edges that land on the same clock show whether the merge produces a wider or doubled pulse. A mode switch made just after a reference changed tests whether history follows the references in every mode. Release from reset with references held high confirms that history starts at zero.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;

    localparam int MODE_W    = 4;
    localparam int REF_COUNT = 6;
    localparam int REF_BASE  = 4;   // first mode that copies a reference
    localparam int CH4_IDX   = 3;
    localparam int CH5_IDX   = 4;
    localparam int CH6_IDX   = 5;

    typedef enum logic [MODE_W-1:0] {
        TS_SWUPD        = 4'd0,
        TS_CNTEN        = 4'd1,
        TS_UPDEVT       = 4'd2,
        TS_CC1PULSE     = 4'd3,
        TS_REF1         = 4'd4,
        TS_REF2         = 4'd5,
        TS_REF3         = 4'd6,
        TS_REF4         = 4'd7,
        TS_REF5         = 4'd8,
        TS_REF6         = 4'd9,
        TS_BOTH4        = 4'd10,
        TS_BOTH6        = 4'd11,
        TS_RISE4_RISE6  = 4'd12,
        TS_RISE4_FALL6  = 4'd13,
        TS_RISE5_RISE6  = 4'd14,
        TS_RISE5_FALL6  = 4'd15
    } trig_mode_e;

    typedef struct packed {
        logic [REF_COUNT-1:0] ref_hist;
        logic                 cc1_hist;
        logic                 trig;
    } trig_state_t;

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise[g] = cur[g] & ~prev[g];
        assign fall[g] = ~cur[g] & prev[g];
    end
endmodule

// File: rtl/trig_mode_mux.sv
module trig_mode_mux
    import trig_sel_pkg::*;
(
    input  logic [MODE_W-1:0]    mode_sel,
    input  logic                 sw_update,
    input  logic                 cnt_en,
    input  logic                 upd_evt,
    input  logic                 cc1_rise,
    input  logic [REF_COUNT-1:0] oc_ref,
    input  logic [REF_COUNT-1:0] ref_rise,
    input  logic [REF_COUNT-1:0] ref_fall,
    output logic                 trig_nxt
);
    always_comb begin
        trig_nxt = 1'b0;
        case (mode_sel)
            TS_SWUPD:       trig_nxt = sw_update;
            TS_CNTEN:       trig_nxt = cnt_en;
            TS_UPDEVT:      trig_nxt = upd_evt;
            TS_CC1PULSE:    trig_nxt = cc1_rise;
            TS_BOTH4:       trig_nxt = ref_rise[CH4_IDX] | ref_fall[CH4_IDX];
            TS_BOTH6:       trig_nxt = ref_rise[CH6_IDX] | ref_fall[CH6_IDX];
            TS_RISE4_RISE6: trig_nxt = ref_rise[CH4_IDX] | ref_rise[CH6_IDX];
            TS_RISE4_FALL6: trig_nxt = ref_rise[CH4_IDX] | ref_fall[CH6_IDX];
            TS_RISE5_RISE6: trig_nxt = ref_rise[CH5_IDX] | ref_rise[CH6_IDX];
            TS_RISE5_FALL6: trig_nxt = ref_rise[CH5_IDX] | ref_fall[CH6_IDX];
            default: begin
                for (int i = 0; i < REF_COUNT; i++) begin
                    if (mode_sel == MODE_W'(REF_BASE + i))
                        trig_nxt = oc_ref[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
    import trig_sel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_sel,
    input  logic                 sw_update,
    input  logic                 cnt_en,
    input  logic                 upd_evt,
    input  logic                 cc1_flag_set,
    input  logic [REF_COUNT-1:0] oc_ref,
    output logic                 trig_out
);
    trig_state_t          state_d, state_q;
    logic [REF_COUNT-1:0] ref_rise, ref_fall;
    logic                 cc1_rise;
    logic                 trig_nxt;

    trig_edge_detect #(.W(REF_COUNT)) u_edges (
        .cur  (oc_ref),
        .prev (state_q.ref_hist),
        .rise (ref_rise),
        .fall (ref_fall)
    );

    trig_mode_mux u_mux (
        .mode_sel  (mode_sel),
        .sw_update (sw_update),
        .cnt_en    (cnt_en),
        .upd_evt   (upd_evt),
        .cc1_rise  (cc1_rise),
        .oc_ref    (oc_ref),
        .ref_rise  (ref_rise),
        .ref_fall  (ref_fall),
        .trig_nxt  (trig_nxt)
    );

    always_comb begin
        cc1_rise         = cc1_flag_set & ~state_q.cc1_hist;
        state_d          = state_q;
        state_d.ref_hist = oc_ref;        // tracked in every mode
        state_d.cc1_hist = cc1_flag_set;
        state_d.trig     = trig_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign trig_out = state_q.trig;

    // R2
    cnt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == TS_CNTEN |=> trig_out == $past(cnt_en));

    // R4
    ref1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == TS_REF1 |=> trig_out == $past(oc_ref[0]));

    // R3
    cc1_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == TS_CC1PULSE && cc1_flag_set && state_q.cc1_hist) |=> !trig_out);

    // R5
    no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == TS_BOTH4 && oc_ref[CH4_IDX] == state_q.ref_hist[CH4_IDX]) |=> !trig_out);

    // R6
    rise6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == TS_RISE4_RISE6 && oc_ref[CH6_IDX] && !state_q.ref_hist[CH6_IDX]) |=> trig_out);

    // R9
    hist_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_q.ref_hist == $past(oc_ref));

endmodule

// File: tb/sim_trig_out_sel.sv
`timescale 1ns/1ps
module sim_trig_out_sel;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] mode_sel;
    logic       sw_update, cnt_en, upd_evt, cc1_flag_set;
    logic [5:0] oc_ref;
    logic       trig_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trig_out_sel u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_update(sw_update),
        .cnt_en(cnt_en), .upd_evt(upd_evt), .cc1_flag_set(cc1_flag_set),
        .oc_ref(oc_ref), .trig_out(trig_out)
    );

    // row: mode[14:11] sw[10] cnt[9] upd[8] cc1[7] ref[6:1] (bit 6 = ch6) expected[0]
    localparam int NV = 40;
    localparam logic [14:0] VEC [NV] = '{
        15'b0000_1_0_0_0_000000_1,  //  0 R2 sw
        15'b0000_0_0_0_0_000000_0,  //  1 R2
        15'b0001_0_1_0_0_000000_1,  //  2 R2 cnt
        15'b0001_0_0_0_0_000000_0,  //  3 R2
        15'b0010_0_0_1_0_000000_1,  //  4 R2 upd
        15'b0011_0_0_0_1_000000_1,  //  5 R3 strobe rises
        15'b0011_0_0_0_1_000000_0,  //  6 R3 held
        15'b0011_0_0_0_0_000000_0,  //  7 R3
        15'b0100_0_0_0_0_000001_1,  //  8 R4 ref1
        15'b0101_0_0_0_0_000010_1,  //  9 R4 ref2
        15'b0110_0_0_0_0_000100_1,  // 10 R4 ref3
        15'b0111_0_0_0_0_001000_1,  // 11 R4 ref4
        15'b1000_0_0_0_0_010000_1,  // 12 R4 ref5
        15'b1001_0_0_0_0_100000_1,  // 13 R4 ref6
        15'b1001_0_0_0_0_011111_0,  // 14 R4 others high
        15'b1010_0_0_0_0_011111_0,  // 15 R5 no edge
        15'b1010_0_0_0_0_010111_1,  // 16 R5 ch4 fall
        15'b1010_0_0_0_0_010111_0,  // 17 R11
        15'b1010_0_0_0_0_011111_1,  // 18 R5 ch4 rise
        15'b1011_0_0_0_0_111111_1,  // 19 R5 ch6 rise
        15'b1011_0_0_0_0_011111_1,  // 20 R5 ch6 fall
        15'b1100_0_0_0_0_111111_1,  // 21 R6 ch6 rise
        15'b1100_0_0_0_0_110111_0,  // 22 R6 ch4 fall ignored
        15'b1101_0_0_0_0_010111_1,  // 23 R7 ch6 fall
        15'b1101_0_0_0_0_011111_1,  // 24 R7 ch4 rise
        15'b1101_0_0_0_0_111111_0,  // 25 R7 ch6 rise ignored
        15'b1101_0_0_0_0_110111_0,  // 26 R7 ch4 fall ignored
        15'b1110_0_0_0_0_100111_0,  // 27 R6 ch5 fall ignored
        15'b1110_0_0_0_0_110111_1,  // 28 R6 ch5 rise
        15'b1111_0_0_0_0_010111_1,  // 29 R7 ch6 fall
        15'b1111_0_0_0_0_000111_0,  // 30 R7 ch5 fall ignored
        15'b1111_0_0_0_0_110111_1,  // 31 R7 ch5 rise + ch6 rise
        15'b1100_0_0_0_0_111111_1,  // 32 R6 ch4 rise
        15'b1100_0_0_0_0_010111_0,  // 33 R6 both fall
        15'b1100_0_0_0_0_111111_1,  // 34 R8 both rise
        15'b1100_0_0_0_0_111111_0,  // 35 R8 R11 single pulse
        15'b0100_0_0_0_0_011111_1,  // 36 R9 ch6 falls under mode 4
        15'b1011_0_0_0_0_011111_0,  // 37 R9 no stale edge
        15'b0100_0_0_0_0_011111_1,  // 38 R10
        15'b0101_0_0_0_0_011101_0   // 39 R10 new mode at once
    };

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (trig_out !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_out=%b expected=%b", tag, trig_out, exp);
        end
    endtask

    task automatic drive(input logic [14:0] v);
        mode_sel     = v[14:11];
        sw_update    = v[10];
        cnt_en       = v[9];
        upd_evt      = v[8];
        cc1_flag_set = v[7];
        oc_ref       = v[6:1];
    endtask

    task automatic step(input logic [14:0] v, input string tag);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #2;
        check(v[0], tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset with every source high
        rst_n = 1'b0;
        drive(15'b0100_1_1_1_1_111111_0);
        repeat (3) @(posedge clk);
        #2;
        check(1'b0, "R1 output during reset");
        // R1: history is zero, so held-high refs show as rising edges
        @(negedge clk);
        rst_n = 1'b1;
        drive(15'b1100_0_0_0_0_111111_0);
        @(posedge clk); #2;
        check(1'b1, "R1 first edge after release");
        step(15'b1100_0_0_0_0_111111_0, "R11 pulse ends");
        step(15'b1100_0_0_0_0_000000_0, "R6 falls ignored");

        for (int i = 0; i < NV; i++)
            step(VEC[i], $sformatf("R-row%0d", i));

        // R1: reset in the middle of a run
        step(15'b0100_0_0_0_0_000001_1, "R4 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(1'b0, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(15'b1010_0_0_0_0_000000_0);
        @(posedge clk); #2;
        check(1'b0, "R1 R5 cleared history, no edge");

        done = 1'b1;
        finish_run();
    end
endmodule